// File: doc/BRIEF.md
# Nibble Bitmap Video Scan Fetcher

This block drives a monochrome raster of 336 pixels by 192 lines. Each pixel is one bit of a 4-bit word in video memory. The block keeps a pixel phase counter, a nibble counter, a line-in-group counter and a group counter. From these it forms the video memory read address for each nibble. It reads the nibble through a synchronous read port with one cycle of latency. It then shifts the nibble out one pixel per clock, most significant bit first.

Video memory is interleaved at nibble granularity. The frame has 12 groups of 16 scanlines. Nibbles next to each other on a scanline lie 16 addresses apart. Scanlines next to each other in a group lie 1 address apart. The horizontal and vertical totals equal the visible sizes, so there is no blanking. The stream of pixels runs without gaps, one frame every 64512 clocks.

The pixel stream has a valid qualifier and no ready input. The display consumes one pixel on every clock and cannot apply back-pressure. Once valid rises it stays high until the next reset. Line and frame start strobes mark the first pixel of each line and of each frame.

Top module: `nibble_scan_fetcher`

## Requirements
- R1: A synchronous active-high reset clears all counters. In the clock after a reset edge, `vram_rd`, `pix_valid`, `line_start`, `frame_start` and `pix_data` are all 0.
- R2: After reset is released, `vram_rd` is 1 in cycle 0 and in every fourth cycle after it. It is 0 in all other cycles.
- R3: The first read of scanline L uses address (L/16)*1344 + (L mod 16).
- R4: Each later read within a scanline uses the previous read's address plus 16. There are 84 reads per scanline.
- R5: Each nibble is shown over four clocks: bit 3 first, then bit 2, bit 1 and bit 0. A bit value of 1 gives `pix_data` = 1 (foreground).
- R6: Pixel p of the frame (p = line*336 + x) appears on `pix_data` in cycle 4 + p after reset release. The memory latency is hidden by fetching one nibble period ahead.
- R7: `line_start` is 1 for exactly the cycle that shows pixel x = 0 of each line. It is 0 at all other times.
- R8: `frame_start` is 1 for exactly the cycle that shows pixel 0 of line 0. It is always 1 together with `line_start`.
- R9: `pix_valid` and `pix_data` are 0 in cycles 0 to 3 after reset release. From cycle 4 on, `pix_valid` stays 1.
- R10: After the last nibble of line 191, the next read returns to address 0. The frame repeats every 64512 clocks with no blanking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| vram_rd | output | 1 | Read strobe to video memory |
| vram_addr | output | 14 | Nibble address; valid while `vram_rd` is 1 |
| vram_data | input | 4 | Read data, valid one clock after the read |
| pix_data | output | 1 | Serial pixel, 1 = foreground |
| pix_valid | output | 1 | Pixel stream qualifier; no back-pressure |
| line_start | output | 1 | Marks pixel 0 of each line |
| frame_start | output | 1 | Marks pixel 0 of line 0 |

## Verification
The first run fills video memory with seeded random nibbles. It then follows a whole frame and the start of the next. Every pixel, every read address and both strobes are checked against a model of the interleaved layout. This separates a wrong group stride, a wrong step within a line, a wrong bit order and an off-by-one latency. The second run resets in the middle of a line and refills memory with a directed pattern: nibbles 4'b1000 and 4'b0001 alternate with the address. This shows that reset returns the scan to address 0, phase 0, and that the MSB-first order is kept.

// File: rtl/vscan_pkg.sv
package vscan_pkg;
  localparam int DEF_H_PIX       = 336;
  localparam int DEF_V_LINES     = 192;
  localparam int DEF_GROUP_LINES = 16;
  localparam int DEF_NIB_W       = 4;
  localparam int DEF_ADDR_W      = 14;
endpackage

// File: rtl/vscan_counters.sv
module vscan_counters #(
  parameter int NIB_W         = 4,
  parameter int NIBS_PER_LINE = 84,
  parameter int GROUP_LINES   = 16,
  parameter int GROUPS        = 12,
  localparam int PH_W  = $clog2(NIB_W),
  localparam int NC_W  = $clog2(NIBS_PER_LINE),
  localparam int LG_W  = $clog2(GROUP_LINES),
  localparam int GR_W  = $clog2(GROUPS)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] phase,
  output logic [NC_W-1:0] nib,
  output logic [LG_W-1:0] lig,
  output logic [GR_W-1:0] grp
);
  logic ph_end, nib_end, lig_end, grp_end;
  assign ph_end  = (phase == PH_W'(NIB_W - 1));
  assign nib_end = (nib == NC_W'(NIBS_PER_LINE - 1));
  assign lig_end = (lig == LG_W'(GROUP_LINES - 1));
  assign grp_end = (grp == GR_W'(GROUPS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      nib   <= '0;
      lig   <= '0;
      grp   <= '0;
    end else begin
      phase <= ph_end ? '0 : phase + 1'b1;
      if (ph_end) begin
        nib <= nib_end ? '0 : nib + 1'b1;
        if (nib_end) begin
          lig <= lig_end ? '0 : lig + 1'b1;
          if (lig_end) grp <= grp_end ? '0 : grp + 1'b1;
        end
      end
    end
  end

  a_r10_group_range: assert property (@(posedge clk) disable iff (rst)
    grp <= GR_W'(GROUPS - 1));
  a_r4_nib_range: assert property (@(posedge clk) disable iff (rst)
    nib <= NC_W'(NIBS_PER_LINE - 1));
endmodule

// File: rtl/vscan_fetch_addr.sv
module vscan_fetch_addr #(
  parameter int NIB_W         = 4,
  parameter int NIBS_PER_LINE = 84,
  parameter int GROUP_LINES   = 16,
  parameter int GROUPS        = 12,
  parameter int ADDR_W        = 14,
  localparam int PH_W  = $clog2(NIB_W),
  localparam int NC_W  = $clog2(NIBS_PER_LINE),
  localparam int LG_W  = $clog2(GROUP_LINES),
  localparam int GR_W  = $clog2(GROUPS),
  localparam int GROUP_STRIDE = NIBS_PER_LINE * GROUP_LINES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PH_W-1:0]   phase,
  input  logic [NC_W-1:0]   nib,
  input  logic [LG_W-1:0]   lig,
  input  logic [GR_W-1:0]   grp,
  output logic              rd,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] STRIDE_C = ADDR_W'(GROUP_STRIDE);
  localparam logic [ADDR_W-1:0] STEP_C   = ADDR_W'(GROUP_LINES);

  assign rd   = !rst && (phase == '0);
  assign addr = ADDR_W'(grp) * STRIDE_C + ADDR_W'(lig) + ADDR_W'(nib) * STEP_C;

  a_r4_step_in_line: assert property (@(posedge clk) disable iff (rst)
    (rd && nib != '0) |-> addr == $past(addr, NIB_W) + STEP_C);
  a_r2_read_gap: assert property (@(posedge clk) disable iff (rst)
    rd |=> !rd);
  a_r10_frame_origin: assert property (@(posedge clk) disable iff (rst)
    (rd && nib == '0 && lig == '0 && grp == '0) |-> addr == '0);
endmodule

// File: rtl/vscan_serializer.sv
module vscan_serializer #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd,
  input  logic             load,
  input  logic [NIB_W-1:0] rdata,
  output logic             pix
);
  logic             rd_q;
  logic [NIB_W-1:0] hold;
  logic [NIB_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= 1'b0;
      hold <= '0;
      sh   <= '0;
    end else begin
      rd_q <= rd;
      if (rd_q) hold <= rdata;
      if (load) sh <= hold;
      else      sh <= {sh[NIB_W-2:0], 1'b0};
    end
  end

  assign pix = sh[NIB_W-1];

  a_r6_capture_before_load: assert property (@(posedge clk) disable iff (rst)
    rd_q |-> !load);
endmodule

// File: rtl/nibble_scan_fetcher.sv
module nibble_scan_fetcher
  import vscan_pkg::*;
#(
  parameter int H_PIX       = DEF_H_PIX,
  parameter int V_LINES     = DEF_V_LINES,
  parameter int GROUP_LINES = DEF_GROUP_LINES,
  parameter int NIB_W       = DEF_NIB_W,
  parameter int ADDR_W      = DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic              vram_rd,
  output logic [ADDR_W-1:0] vram_addr,
  input  logic [NIB_W-1:0]  vram_data,
  output logic              pix_data,
  output logic              pix_valid,
  output logic              line_start,
  output logic              frame_start
);
  localparam int NIBS_PER_LINE = H_PIX / NIB_W;
  localparam int GROUPS        = V_LINES / GROUP_LINES;
  localparam int PH_W = $clog2(NIB_W);
  localparam int NC_W = $clog2(NIBS_PER_LINE);
  localparam int LG_W = $clog2(GROUP_LINES);
  localparam int GR_W = $clog2(GROUPS);

  logic [PH_W-1:0] phase;
  logic [NC_W-1:0] nib;
  logic [LG_W-1:0] lig;
  logic [GR_W-1:0] grp;
  logic            load;

  vscan_counters #(
    .NIB_W(NIB_W), .NIBS_PER_LINE(NIBS_PER_LINE),
    .GROUP_LINES(GROUP_LINES), .GROUPS(GROUPS)
  ) u_cnt (
    .clk(clk), .rst(rst), .phase(phase), .nib(nib), .lig(lig), .grp(grp)
  );

  vscan_fetch_addr #(
    .NIB_W(NIB_W), .NIBS_PER_LINE(NIBS_PER_LINE),
    .GROUP_LINES(GROUP_LINES), .GROUPS(GROUPS), .ADDR_W(ADDR_W)
  ) u_addr (
    .clk(clk), .rst(rst), .phase(phase), .nib(nib), .lig(lig), .grp(grp),
    .rd(vram_rd), .addr(vram_addr)
  );

  assign load = (phase == PH_W'(NIB_W - 1));

  vscan_serializer #(.NIB_W(NIB_W)) u_ser (
    .clk(clk), .rst(rst), .rd(vram_rd), .load(load),
    .rdata(vram_data), .pix(pix_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      line_start  <= 1'b0;
      frame_start <= 1'b0;
      pix_valid   <= 1'b0;
    end else begin
      line_start  <= load && nib == '0;
      frame_start <= load && nib == '0 && lig == '0 && grp == '0;
      pix_valid   <= pix_valid | load;
    end
  end

  a_r8_frame_with_line: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> line_start);
  a_r9_valid_sticky: assert property (@(posedge clk) disable iff (rst)
    pix_valid |=> pix_valid);
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pix_valid && !line_start && !frame_start && !pix_data));
  a_r7_line_single: assert property (@(posedge clk) disable iff (rst)
    line_start |=> !line_start);
endmodule

// File: tb/nibble_scan_fetcher_test.sv
module nibble_scan_fetcher_test;
  localparam int HP = 336;
  localparam int FRAME_PIX = 336 * 192;
  localparam int FRAME_NIB = 84 * 192;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vram_rd;
  logic [13:0] vram_addr;
  logic [3:0]  vram_data;
  logic        pix_data, pix_valid, line_start, frame_start;

  logic [3:0] mem [0:16383];
  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nibble_scan_fetcher uut (
    .clk(clk), .rst(rst), .vram_rd(vram_rd), .vram_addr(vram_addr),
    .vram_data(vram_data), .pix_data(pix_data), .pix_valid(pix_valid),
    .line_start(line_start), .frame_start(frame_start)
  );

  always @(posedge clk) if (vram_rd) vram_data <= mem[vram_addr];

  function automatic int addr_of(int line, int nb);
    return (line / 16) * 1344 + (line % 16) + 16 * nb;
  endfunction

  function automatic int exp_addr(int n);
    int f;
    f = (n / 4) % FRAME_NIB;
    return addr_of(f / 84, f % 84);
  endfunction

  function automatic logic exp_pix(int n);
    int p, x;
    logic [3:0] v;
    p = (n - 4) % FRAME_PIX;
    x = p % HP;
    v = mem[addr_of(p / HP, x / 4)];
    return v[3 - (x % 4)];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      report();
    end
  end

  task automatic check_reset_state();
    chk(vram_rd == 1'b0, "R1 rd", vram_rd, 0);
    chk(pix_valid == 1'b0, "R1 valid", pix_valid, 0);
    chk(line_start == 1'b0 && frame_start == 1'b0, "R1 strobes",
        {line_start, frame_start}, 0);
    chk(pix_data == 1'b0, "R1 pix", pix_data, 0);
  endtask

  task automatic run_window(input int ncyc);
    @(negedge clk);
    rst = 1'b0;
    for (int n = 0; n < ncyc; n++) begin
      if (n > 0) @(negedge clk);
      #1;
      chk(vram_rd == (n % 4 == 0), "R2 read cadence", vram_rd, n % 4 == 0);
      if (n % 4 == 0) begin
        int f;
        f = (n / 4) % FRAME_NIB;
        if (n / 4 == FRAME_NIB)
          chk(vram_addr == 14'd0, "R10 frame wrap addr", vram_addr, 0);
        else if (f % 84 == 0)
          chk(int'(vram_addr) == exp_addr(n), "R3 line first addr", vram_addr, exp_addr(n));
        else
          chk(int'(vram_addr) == exp_addr(n), "R4 step addr", vram_addr, exp_addr(n));
      end
      if (n < 4) begin
        chk(pix_valid == 1'b0 && pix_data == 1'b0, "R9 prime", {pix_valid, pix_data}, 0);
        chk(line_start == 1'b0 && frame_start == 1'b0, "R7 R8 prime quiet",
            {line_start, frame_start}, 0);
      end else begin
        int p;
        p = (n - 4) % FRAME_PIX;
        chk(pix_valid == 1'b1, "R9 valid held", pix_valid, 1);
        chk(pix_data == exp_pix(n), "R5 R6 pixel", pix_data, exp_pix(n));
        chk(line_start == (p % HP == 0), "R7 line_start", line_start, p % HP == 0);
        chk(frame_start == (p == 0), "R8 frame_start", frame_start, p == 0);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 16384; i++) mem[i] = 4'($urandom);
    mem[0] = 4'b1000;
    mem[16] = 4'b0001;
    repeat (3) @(negedge clk);
    #1;
    check_reset_state();
    run_window(FRAME_PIX + 4 + 400);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    #1;
    check_reset_state();
    for (int i = 0; i < 16384; i++) mem[i] = i[0] ? 4'b0001 : 4'b1000;
    run_window(1500);
    report();
  end
endmodule